// File: doc/BRIEF.md
# Reloadable Up-Counting Watchdog Timer

This block supervises firmware with a wide up-counter that advances once per processor machine cycle. Firmware must keep writing a reload byte before the count runs out. Each write places the byte in the upper bits of the counter and zeroes the lower bits. A larger byte therefore leaves fewer steps before timeout, and a zero byte leaves the longest interval.

A machine cycle normally lasts four clocks. When the transfer-active input is high and the configured bus cycle length is above four, a machine cycle lasts that many clocks instead. Every clock with the stall input high adds one more clock, and the count holds during that clock.

Once the counter holds all ones, the block clears the counter on the next clock and raises its reset request for a fixed number of clocks. Counting then carries on from zero.

Top module: `wdog_upcount`

## Requirements
- R1: While the synchronous active-high `rst` is high, and after it falls, `wdt_rst` is low and the count and machine-cycle phase are zero. With no write after reset, the first `wdt_rst` rise comes 4*(2^CNT_W-1)+1 clocks after the last clock edge with `rst` high.
- R2: A write (`wr_en` high at a clock edge) loads the upper RELOAD_W bits of the count with `wr_data` and clears the lower CNT_W-RELOAD_W bits. The machine-cycle phase restarts at the same edge. With four-clock machine cycles and no stall, `wdt_rst` first rises L*N+1 clocks after the write edge, where N = 2^CNT_W-1 - V*2^(CNT_W-RELOAD_W), V is the written value, and L is the machine-cycle length in clocks.
- R3: The count rises by exactly one per machine cycle, not per clock. With `xfer_act` low a machine cycle is 4 clocks whatever `bus_len` holds.
- R4: With `xfer_act` high a machine cycle lasts `bus_len` clocks when `bus_len` is greater than 4 (codes 5, 6, 7), and 4 clocks for codes 0 to 4.
- R5: Each clock with `stall` high lengthens the current machine cycle by one clock, and the count does not change in that clock.
- R6: When the count holds all ones and no write occurs, the next edge clears the count to zero and `wdt_rst` is high for exactly RST_HOLD clocks (default 4).
- R7: After a timeout, counting resumes from zero with a fresh machine cycle. With no write, the next `wdt_rst` rise follows the previous rise by 4*(2^CNT_W-1)+1 clocks.
- R8: A write takes priority over an increment in the same clock, so the count equals the loaded value and not the value plus one. A write takes priority over a pending timeout in the clock where the count holds all ones, so no `wdt_rst` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Reload write strobe |
| wr_data | input | RELOAD_W (8) | Reload value for the upper count bits |
| bus_len | input | LEN_W (3) | Bus cycle length in clocks, effective range 4 to 7 |
| xfer_act | input | 1 | Current machine cycle performs a memory transfer |
| stall | input | 1 | Stall, holds the machine cycle for this clock |
| wdt_rst | output | 1 | Timeout reset request |

## Verification
The assertions watch every cycle for these properties:
- a write loads the value with the low bits cleared;
- an unstalled machine-cycle end adds exactly one to the count;
- a stalled clock leaves the count unchanged;
- machine-cycle ends are never closer than four clocks apart;
- a held all-ones count is always followed by a zero count and a raised reset request.

Only the bench scenarios can show the absolute timing. This covers the exact clock distance from a write or reset to the reset request for several reload values, bus lengths and stall runs. It also covers the pulse width, the spacing of back-to-back timeouts, and a write that lands on the terminal clock or on a machine-cycle end.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Clocks in one machine cycle, before stalls are added.
  function automatic int unsigned mcyc_len(input logic xfer,
                                           input int unsigned bus_cyc,
                                           input int unsigned base_cyc);
    if (xfer && (bus_cyc > base_cyc)) return bus_cyc;
    return base_cyc;
  endfunction

  // Increments remaining from a reload until the all-ones value.
  function automatic longint unsigned steps_left(input int unsigned cnt_w,
                                                 input int unsigned load_w,
                                                 input longint unsigned value);
    return ((64'd1 << cnt_w) - 64'd1) - (value << (cnt_w - load_w));
  endfunction

endpackage

// File: rtl/wdog_mcyc_tick.sv
module wdog_mcyc_tick #(
  parameter int LEN_W    = 3,
  parameter int BASE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stall,
  input  logic             xfer,
  input  logic [LEN_W-1:0] bus_len,
  output logic             tick
);
  import wdog_pkg::*;

  localparam int PH_W  = LEN_W;
  localparam int CL_W  = PH_W + 1;
  localparam int GAP_W = CL_W + 2;

  logic [PH_W-1:0] phase;
  logic [CL_W-1:0] cyc_len;
  logic            last_clk;

  assign cyc_len  = CL_W'(mcyc_len(xfer, 32'(bus_len), BASE_CYC));
  assign last_clk = ({1'b0, phase} >= (cyc_len - CL_W'(1)));
  assign tick     = !stall && last_clk;

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (tick)   phase <= '0;
    else if (!stall) phase <= phase + PH_W'(1);
  end

  // Clocks since the previous machine-cycle end, for the spacing check.
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst || clr || tick)      gap <= '0;
    else if (gap != '1)          gap <= gap + GAP_W'(1);
  end

  // R3: machine-cycle ends are at least BASE_CYC clocks apart
  a_r3_min_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap >= GAP_W'(BASE_CYC - 1)));

  // R5: a stalled clock never ends the machine cycle
  a_r5_stall_phase: assert property (@(posedge clk) disable iff (rst)
    (stall && !clr) |=> $stable(phase));

endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core #(
  parameter int CNT_W  = 24,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LOAD_W-1:0] wr_data,
  input  logic              tick,
  output logic [CNT_W-1:0]  cnt,
  output logic              terminal,
  output logic              timeout_evt
);
  localparam int LOW_W = CNT_W - LOAD_W;

  logic [CNT_W-1:0] load_word;

  assign load_word   = {wr_data, {LOW_W{1'b0}}};
  assign terminal    = (cnt == {CNT_W{1'b1}});
  assign timeout_evt = terminal && !wr_en;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (wr_en)    cnt <= load_word;
    else if (terminal) cnt <= '0;
    else if (tick)     cnt <= cnt + CNT_W'(1);
  end

  // R2: a write places the byte on top and zeroes the rest
  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt[CNT_W-1:LOW_W] == $past(wr_data)) && (cnt[LOW_W-1:0] == '0));

  // R3: one step per machine-cycle end
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !terminal) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R6: a held all-ones count wraps to zero
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> (cnt == '0));

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst)            hold <= '0;
    else if (fire)      hold <= HW'(HOLD);
    else if (hold != 0) hold <= hold - HW'(1);
  end

  assign pulse = (hold != '0);

  // R6: a timeout raises the request on the next clock
  a_r6_fire_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse);

  // R6: the request only rises after a timeout
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(fire));

endmodule

// File: rtl/wdog_upcount.sv
module wdog_upcount #(
  parameter int CNT_W    = 24,
  parameter int RELOAD_W = 8,
  parameter int LEN_W    = 3,
  parameter int BASE_CYC = 4,
  parameter int RST_HOLD = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [RELOAD_W-1:0] wr_data,
  input  logic [LEN_W-1:0]    bus_len,
  input  logic                xfer_act,
  input  logic                stall,
  output logic                wdt_rst
);
  logic             mc_tick;
  logic             phase_clr;
  logic [CNT_W-1:0] cnt;
  logic             terminal;
  logic             timeout_evt;

  assign phase_clr = wr_en || timeout_evt;

  wdog_mcyc_tick #(.LEN_W(LEN_W), .BASE_CYC(BASE_CYC)) i_tick (
    .clk(clk), .rst(rst), .clr(phase_clr), .stall(stall),
    .xfer(xfer_act), .bus_len(bus_len), .tick(mc_tick)
  );

  wdog_count_core #(.CNT_W(CNT_W), .LOAD_W(RELOAD_W)) i_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(mc_tick),
    .cnt(cnt), .terminal(terminal), .timeout_evt(timeout_evt)
  );

  wdog_rst_pulse #(.HOLD(RST_HOLD)) i_pulse (
    .clk(clk), .rst(rst), .fire(timeout_evt), .pulse(wdt_rst)
  );

  // R5: the count holds through a stalled clock
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    (stall && !wr_en && !terminal) |=> $stable(cnt));

  // R8: a write on the terminal clock suppresses the request
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (terminal && wr_en && !wdt_rst) |=> !wdt_rst);

endmodule

// File: tb/test_wdog_upcount.sv
`timescale 1ns/1ps
module test_wdog_upcount;
  localparam int CW   = 12;
  localparam int LW   = 4;
  localparam int FULL = (1 << CW) - 1;
  localparam int NV   = 9;

  // reload, xfer_act, bus_len, stall clocks, expected rise distance
  localparam int T_VAL [NV] = '{15, 14, 15, 15, 15, 15, 15, 12, 0};
  localparam int T_XFR [NV] = '{ 0,  0,  0,  1,  1,  1,  0,  1, 0};
  localparam int T_LEN [NV] = '{ 0,  0,  7,  6,  7,  2,  0,  5, 0};
  localparam int T_STL [NV] = '{ 0,  0,  0,  0,  0,  0, 10,  3, 0};
  localparam int T_EXP [NV] = '{1021, 2045, 1021, 1531, 1786, 1021, 1031, 5119, 16381};

  logic clk = 0, rst = 1, wr_en = 0, xfer = 0, stall = 0;
  logic [LW-1:0] wr_data = '0;
  logic [2:0] bus_len = '0;
  logic wdt_rst;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, w0 = 0;

  wdog_upcount #(.CNT_W(CW), .RELOAD_W(LW)) i_wdog_upcount (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .bus_len(bus_len),
    .xfer_act(xfer), .stall(stall), .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input int v);
    wr_data = LW'(v);
    wr_en = 1;
    @(posedge clk); #1;
    w0 = cyc;
    wr_en = 0;
  endtask

  task automatic wait_rise(output int k);
    int lim = 0;
    k = -1;
    forever begin
      @(negedge clk);
      if (wdt_rst) begin k = cyc - w0; break; end
      lim++;
      if (lim > 40000) break;
    end
  endtask

  task automatic width(output int w);
    w = 0;
    while (wdt_rst === 1'b1 && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int k, w;
    repeat (3) @(posedge clk);
    #1;
    check("R1 request low in reset", int'(wdt_rst), 0);
    w0 = cyc;
    rst = 0;
    @(negedge clk);
    check("R1 request low after reset", int'(wdt_rst), 0);
    wait_rise(k);
    check("R1 first timeout from zero", k, 4 * FULL + 1);
    w0 = cyc;
    width(w);
    check("R6 pulse width", w, 4);
    wait_rise(k);
    check("R7 back-to-back timeout spacing", k, 4 * FULL + 1);
    width(w);
    check("R7 pulse width", w, 4);

    // table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      xfer = T_XFR[i][0];
      bus_len = 3'(T_LEN[i]);
      do_write(T_VAL[i]);
      if (T_STL[i] > 0) begin
        @(negedge clk);
        stall = 1;
        repeat (T_STL[i]) @(negedge clk);
        stall = 0;
      end
      wait_rise(k);
      check($sformatf("R2/R3/R4/R5 vector %0d rise", i), k, T_EXP[i]);
      width(w);
      check($sformatf("R6 vector %0d width", i), w, 4);
    end
    xfer = 0;
    bus_len = '0;

    // R8: a write on the terminal clock beats the timeout
    do_write(15);
    repeat (1020) @(posedge clk);
    @(negedge clk);
    check("R8 request low before terminal write", int'(wdt_rst), 0);
    do_write(15);
    wait_rise(k);
    check("R8 terminal write suppresses pulse", k, 1021);
    width(w);

    // R8: a write on a machine-cycle end beats the increment
    do_write(15);
    repeat (3) @(posedge clk);
    @(negedge clk);
    do_write(15);
    wait_rise(k);
    check("R8 write beats increment", k, 1021);
    width(w);

    summary();
  end
endmodule